// File: doc/BRIEF.md
# Two-Level IO Page Table Walker

This block turns a 36-bit IO virtual address into a 36-bit physical address. It does this by reading up to two 32-bit descriptors from a page table held in memory. Three mapping sizes are supported: a 1 MB section taken from the first level, and a 64 KB large page or a 4 KB small page taken from the second level. A descriptor holds a physical address that has been shifted right by four bits. This lets a 32-bit entry reach the whole 36-bit physical space.

A client offers an address on the request port. The walker accepts it only while idle. It captures the address together with the level-1 table base, then issues descriptor reads on a memory port. That port has valid/ready on the read request and on the read response. When the walk ends, the response port holds one of two results until the client takes it: a translated address with its page size and shareable attribute, or a fault code. Only one walk is in flight at any time.

Top module: `ptw_walker`

## Requirements
- R1: After reset, and whenever no walk is in progress, req_ready_o is 1, mem_req_valid_o is 0 and rsp_valid_o is 0. While a walk is in progress or a result is waiting, req_ready_o is 0 and req_valid_i is ignored.
- R2: The first descriptor read goes to the captured base plus four times IOVA bits [35:20].
- R3: A level-1 descriptor whose bits [2:0] equal 2 ends the walk without a fault. The result has PA = {desc[31:16], iova[19:0]}, rsp_size_o = 0 (1 MB) and rsp_share_o = desc bit 6.
- R4: A level-1 descriptor whose bits [2:0] equal 1 starts a second read. Its address is {desc[31:6], 10'b0} + 4 * iova[19:12].
- R5: A level-2 descriptor whose bits [1:0] equal 1 gives a result with PA = {desc[31:12], iova[15:0]}, rsp_size_o = 1 (64 KB) and rsp_share_o = desc bit 4.
- R6: A level-2 descriptor whose bits [1:0] equal 2 gives a result with PA = {desc[31:8], iova[11:0]}, rsp_size_o = 2 (4 KB) and rsp_share_o = desc bit 4.
- R7: Level-1 type values 0, 3, 4, 5, 6 and 7, and level-2 type values 0 and 3, end the walk with rsp_fault_o = 1 and rsp_fault_code_o = 1 (page fault). No further memory read is issued after such a descriptor.
- R8: A read response with mem_rsp_err_i = 1, at either level, ends the walk with rsp_fault_o = 1 and rsp_fault_code_o = 0. Every response, faulting or not, reports the request IOVA on rsp_iova_o.
- R9: While rsp_valid_o = 1 and rsp_ready_i = 0, every response output stays unchanged. A cycle with rsp_ready_i = 1 returns the walker to idle.
- R10: While mem_req_valid_o = 1 and mem_req_ready_i = 0, the request stays asserted and its address stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l1_base_i | input | 36 | Level-1 table base, captured when a request is accepted |
| req_valid_i | input | 1 | Translation request offered |
| req_ready_o | output | 1 | Walker idle, request accepted this cycle |
| req_iova_i | input | 36 | IO virtual address to translate |
| mem_req_valid_o | output | 1 | Descriptor read request |
| mem_req_ready_i | input | 1 | Memory accepts the read request |
| mem_req_addr_o | output | 36 | Byte address of the descriptor |
| mem_rsp_valid_i | input | 1 | Read data returned |
| mem_rsp_ready_o | output | 1 | Walker waiting for read data |
| mem_rsp_data_i | input | 32 | Descriptor value |
| mem_rsp_err_i | input | 1 | Read failed |
| rsp_valid_o | output | 1 | Walk result available |
| rsp_ready_i | input | 1 | Client takes the result |
| rsp_pa_o | output | 36 | Translated physical address, 0 on a fault |
| rsp_size_o | output | 2 | 0 = 1 MB, 1 = 64 KB, 2 = 4 KB |
| rsp_share_o | output | 1 | Shareable attribute of the mapping |
| rsp_fault_o | output | 1 | Walk ended in a fault |
| rsp_fault_code_o | output | 4 | 0 = memory access error, 1 = page fault |
| rsp_iova_o | output | 36 | IOVA of the walk being reported |

## Verification
The bench builds the walker with its default parameters: 36-bit addresses, 32-bit descriptors, a 4-bit descriptor shift and page orders 20, 16 and 12. Under that configuration the bench feeds every level-1 type value and, behind each table descriptor, every level-2 type value, across eight IOVA patterns. The patterns include all-zero and all-one addresses, so every offset and index bit reaches the result. It also injects read errors at each level and holds back-pressure of zero to two cycles on the request, response and result handshakes.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int FAULT_W = 4;
  localparam logic [FAULT_W-1:0] FC_WALK_ERR = FAULT_W'(0);
  localparam logic [FAULT_W-1:0] FC_PAGE     = FAULT_W'(1);

  typedef enum logic [1:0] {L1K_FAULT, L1K_TABLE, L1K_SECTION} l1_kind_e;
  typedef enum logic [1:0] {L2K_FAULT, L2K_LARGE, L2K_SMALL}   l2_kind_e;
  typedef enum logic [1:0] {SZ_1M = 2'd0, SZ_64K = 2'd1, SZ_4K = 2'd2} pg_size_e;

  typedef enum logic [2:0] {
    S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_DONE
  } walk_state_e;
endpackage

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode
  import ptw_pkg::*;
#(
  parameter int PA_W        = 36,
  parameter int DESC_W      = 32,
  parameter int PA_SHIFT    = 4,
  parameter int SECT_ORDER  = 20,
  parameter int SPAGE_ORDER = 12,
  parameter int L2_ALIGN    = 6,
  parameter int IDX_SHIFT   = 2,
  parameter int SHARE_BIT   = 6
) (
  input  logic [DESC_W-1:0]     desc_i,
  input  logic [SECT_ORDER-1:0] off_i,
  output l1_kind_e              kind_o,
  output logic [PA_W-1:0]       pa_o,
  output logic [PA_W-1:0]       l2_addr_o,
  output logic                  share_o
);
  localparam logic [PA_W-1:0] OFF_MASK   = PA_W'((64'd1 << SECT_ORDER) - 64'd1);
  localparam logic [PA_W-1:0] ALIGN_MASK = PA_W'((64'd1 << (L2_ALIGN + PA_SHIFT)) - 64'd1);

  logic [PA_W-1:0] desc_pa;
  assign desc_pa   = PA_W'(desc_i) << PA_SHIFT;
  assign pa_o      = (desc_pa & ~OFF_MASK) | (PA_W'(off_i) & OFF_MASK);
  assign l2_addr_o = (desc_pa & ~ALIGN_MASK)
                   + (PA_W'(off_i[SECT_ORDER-1:SPAGE_ORDER]) << IDX_SHIFT);
  assign share_o   = desc_i[SHARE_BIT];

  always_comb begin
    unique case (desc_i[2:0])
      3'd1:    kind_o = L1K_TABLE;
      3'd2:    kind_o = L1K_SECTION;
      default: kind_o = L1K_FAULT;
    endcase
  end
endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
  import ptw_pkg::*;
#(
  parameter int PA_W        = 36,
  parameter int DESC_W      = 32,
  parameter int PA_SHIFT    = 4,
  parameter int LPAGE_ORDER = 16,
  parameter int SPAGE_ORDER = 12,
  parameter int SHARE_BIT   = 4
) (
  input  logic [DESC_W-1:0]      desc_i,
  input  logic [LPAGE_ORDER-1:0] off_i,
  output l2_kind_e               kind_o,
  output logic [PA_W-1:0]        pa_o,
  output pg_size_e               size_o,
  output logic                   share_o
);
  localparam logic [PA_W-1:0] LMASK = PA_W'((64'd1 << LPAGE_ORDER) - 64'd1);
  localparam logic [PA_W-1:0] SMASK = PA_W'((64'd1 << SPAGE_ORDER) - 64'd1);

  logic [PA_W-1:0] desc_pa, off_pa;
  assign desc_pa = PA_W'(desc_i) << PA_SHIFT;
  assign off_pa  = PA_W'(off_i);
  assign share_o = desc_i[SHARE_BIT];

  always_comb begin
    unique case (desc_i[1:0])
      2'd1:    kind_o = L2K_LARGE;
      2'd2:    kind_o = L2K_SMALL;
      default: kind_o = L2K_FAULT;
    endcase
    if (kind_o == L2K_LARGE) begin
      pa_o   = (desc_pa & ~LMASK) | (off_pa & LMASK);
      size_o = SZ_64K;
    end else begin
      pa_o   = (desc_pa & ~SMASK) | (off_pa & SMASK);
      size_o = SZ_4K;
    end
  end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int VA_W       = 36,
  parameter int PA_W       = 36,
  parameter int SECT_ORDER = 20,
  parameter int IDX_SHIFT  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PA_W-1:0]    l1_base_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [VA_W-1:0]    req_iova_i,
  output logic [VA_W-1:0]    iova_o,
  output logic               mem_req_valid_o,
  input  logic               mem_req_ready_i,
  output logic [PA_W-1:0]    mem_req_addr_o,
  input  logic               mem_rsp_valid_i,
  output logic               mem_rsp_ready_o,
  input  logic               mem_rsp_err_i,
  input  l1_kind_e           l1_kind_i,
  input  logic [PA_W-1:0]    l1_pa_i,
  input  logic [PA_W-1:0]    l2_addr_i,
  input  logic               l1_share_i,
  input  l2_kind_e           l2_kind_i,
  input  logic [PA_W-1:0]    l2_pa_i,
  input  pg_size_e           l2_size_i,
  input  logic               l2_share_i,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic [PA_W-1:0]    rsp_pa_o,
  output pg_size_e           rsp_size_o,
  output logic               rsp_share_o,
  output logic               rsp_fault_o,
  output logic [FAULT_W-1:0] rsp_fault_code_o
);
  walk_state_e        state_q;
  logic [VA_W-1:0]    iova_q;
  logic [PA_W-1:0]    base_q, l2_addr_q, l1_addr;

  assign l1_addr = base_q + (PA_W'(iova_q[VA_W-1:SECT_ORDER]) << IDX_SHIFT);

  assign iova_o          = iova_q;
  assign req_ready_o     = (state_q == S_IDLE);
  assign mem_req_valid_o = (state_q == S_L1_REQ) || (state_q == S_L2_REQ);
  assign mem_rsp_ready_o = (state_q == S_L1_WAIT) || (state_q == S_L2_WAIT);
  assign mem_req_addr_o  = (state_q == S_L2_REQ) ? l2_addr_q : l1_addr;
  assign rsp_valid_o     = (state_q == S_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q          <= S_IDLE;
      iova_q           <= '0;
      base_q           <= '0;
      l2_addr_q        <= '0;
      rsp_pa_o         <= '0;
      rsp_size_o       <= SZ_1M;
      rsp_share_o      <= 1'b0;
      rsp_fault_o      <= 1'b0;
      rsp_fault_code_o <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          iova_q  <= req_iova_i;
          base_q  <= l1_base_i;
          state_q <= S_L1_REQ;
        end
        S_L1_REQ: if (mem_req_ready_i) state_q <= S_L1_WAIT;
        S_L1_WAIT: if (mem_rsp_valid_i) begin
          rsp_pa_o    <= '0;
          rsp_size_o  <= SZ_1M;
          rsp_share_o <= 1'b0;
          if (mem_rsp_err_i) begin
            rsp_fault_o      <= 1'b1;
            rsp_fault_code_o <= FC_WALK_ERR;
            state_q          <= S_DONE;
          end else if (l1_kind_i == L1K_SECTION) begin
            rsp_pa_o         <= l1_pa_i;
            rsp_share_o      <= l1_share_i;
            rsp_fault_o      <= 1'b0;
            rsp_fault_code_o <= '0;
            state_q          <= S_DONE;
          end else if (l1_kind_i == L1K_TABLE) begin
            l2_addr_q <= l2_addr_i;
            state_q   <= S_L2_REQ;
          end else begin
            rsp_fault_o      <= 1'b1;
            rsp_fault_code_o <= FC_PAGE;
            state_q          <= S_DONE;
          end
        end
        S_L2_REQ: if (mem_req_ready_i) state_q <= S_L2_WAIT;
        S_L2_WAIT: if (mem_rsp_valid_i) begin
          state_q <= S_DONE;
          if (mem_rsp_err_i || l2_kind_i == L2K_FAULT) begin
            rsp_pa_o         <= '0;
            rsp_size_o       <= SZ_1M;
            rsp_share_o      <= 1'b0;
            rsp_fault_o      <= 1'b1;
            rsp_fault_code_o <= mem_rsp_err_i ? FC_WALK_ERR : FC_PAGE;
          end else begin
            rsp_pa_o         <= l2_pa_i;
            rsp_size_o       <= l2_size_i;
            rsp_share_o      <= l2_share_i;
            rsp_fault_o      <= 1'b0;
            rsp_fault_code_o <= '0;
          end
        end
        S_DONE: if (rsp_ready_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R1: idle excludes any pending read or result
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!mem_req_valid_o && !rsp_valid_o));

  // R10: read request held until accepted
  assert_mem_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  // R9: result held until taken
  assert_rsp_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_pa_o) && $stable(rsp_fault_o)
      && $stable(rsp_fault_code_o) && $stable(rsp_share_o) && $stable(rsp_size_o) && $stable(iova_o)));

  // R8: error response maps to walk access fault
  assert_err_fault_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rsp_ready_o && mem_rsp_valid_i && mem_rsp_err_i) |=>
      (rsp_valid_o && rsp_fault_o && rsp_fault_code_o == FC_WALK_ERR));

  // R3: section result carries the IOVA offset
  assert_section_offset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_L1_WAIT && mem_rsp_valid_i && !mem_rsp_err_i && l1_kind_i == L1K_SECTION) |=>
      (rsp_valid_o && !rsp_fault_o && rsp_pa_o[SECT_ORDER-1:0] == iova_q[SECT_ORDER-1:0]));

  // R7: no read issued directly after a result is produced
  assert_no_fetch_after_result_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsp_valid_o) |-> !mem_req_valid_o);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VA_W        = 36,
  parameter int PA_W        = 36,
  parameter int DESC_W      = 32,
  parameter int PA_SHIFT    = 4,
  parameter int SECT_ORDER  = 20,
  parameter int LPAGE_ORDER = 16,
  parameter int SPAGE_ORDER = 12,
  parameter int L2_ALIGN    = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PA_W-1:0]    l1_base_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [VA_W-1:0]    req_iova_i,
  output logic               mem_req_valid_o,
  input  logic               mem_req_ready_i,
  output logic [PA_W-1:0]    mem_req_addr_o,
  input  logic               mem_rsp_valid_i,
  output logic               mem_rsp_ready_o,
  input  logic [DESC_W-1:0]  mem_rsp_data_i,
  input  logic               mem_rsp_err_i,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic [PA_W-1:0]    rsp_pa_o,
  output logic [1:0]         rsp_size_o,
  output logic               rsp_share_o,
  output logic               rsp_fault_o,
  output logic [FAULT_W-1:0] rsp_fault_code_o,
  output logic [VA_W-1:0]    rsp_iova_o
);
  localparam int IDX_SHIFT = $clog2(DESC_W / 8);

  logic [VA_W-1:0] iova;
  l1_kind_e        l1_kind;
  l2_kind_e        l2_kind;
  logic [PA_W-1:0] l1_pa, l2_addr, l2_pa;
  logic            l1_share, l2_share;
  pg_size_e        l2_size, size_e;

  ptw_l1_decode #(
    .PA_W(PA_W), .DESC_W(DESC_W), .PA_SHIFT(PA_SHIFT), .SECT_ORDER(SECT_ORDER),
    .SPAGE_ORDER(SPAGE_ORDER), .L2_ALIGN(L2_ALIGN), .IDX_SHIFT(IDX_SHIFT), .SHARE_BIT(6)
  ) u_l1 (
    .desc_i(mem_rsp_data_i), .off_i(iova[SECT_ORDER-1:0]), .kind_o(l1_kind),
    .pa_o(l1_pa), .l2_addr_o(l2_addr), .share_o(l1_share)
  );

  ptw_l2_decode #(
    .PA_W(PA_W), .DESC_W(DESC_W), .PA_SHIFT(PA_SHIFT), .LPAGE_ORDER(LPAGE_ORDER),
    .SPAGE_ORDER(SPAGE_ORDER), .SHARE_BIT(4)
  ) u_l2 (
    .desc_i(mem_rsp_data_i), .off_i(iova[LPAGE_ORDER-1:0]), .kind_o(l2_kind),
    .pa_o(l2_pa), .size_o(l2_size), .share_o(l2_share)
  );

  ptw_ctrl #(
    .VA_W(VA_W), .PA_W(PA_W), .SECT_ORDER(SECT_ORDER), .IDX_SHIFT(IDX_SHIFT)
  ) u_ctrl (
    .clk_i, .rst_ni, .l1_base_i, .req_valid_i, .req_ready_o, .req_iova_i,
    .iova_o(iova), .mem_req_valid_o, .mem_req_ready_i, .mem_req_addr_o,
    .mem_rsp_valid_i, .mem_rsp_ready_o, .mem_rsp_err_i,
    .l1_kind_i(l1_kind), .l1_pa_i(l1_pa), .l2_addr_i(l2_addr), .l1_share_i(l1_share),
    .l2_kind_i(l2_kind), .l2_pa_i(l2_pa), .l2_size_i(l2_size), .l2_share_i(l2_share),
    .rsp_valid_o, .rsp_ready_i, .rsp_pa_o, .rsp_size_o(size_e), .rsp_share_o,
    .rsp_fault_o, .rsp_fault_code_o
  );

  assign rsp_size_o = size_e;
  assign rsp_iova_o = iova;
endmodule

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [35:0] l1_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [35:0] req_iova = '0;
  logic        mreq_valid, mreq_ready = 1'b0;
  logic [35:0] mreq_addr;
  logic        mrsp_valid = 1'b0, mrsp_ready, mrsp_err = 1'b0;
  logic [31:0] mrsp_data = '0;
  logic        rsp_valid, rsp_ready = 1'b0;
  logic [35:0] rsp_pa, rsp_iova;
  logic [1:0]  rsp_size;
  logic        rsp_share, rsp_fault;
  logic [3:0]  rsp_code;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  ptw_walker u0 (
    .clk_i(clk), .rst_ni(rst_n), .l1_base_i(l1_base),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_iova_i(req_iova),
    .mem_req_valid_o(mreq_valid), .mem_req_ready_i(mreq_ready), .mem_req_addr_o(mreq_addr),
    .mem_rsp_valid_i(mrsp_valid), .mem_rsp_ready_o(mrsp_ready),
    .mem_rsp_data_i(mrsp_data), .mem_rsp_err_i(mrsp_err),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_pa_o(rsp_pa),
    .rsp_size_o(rsp_size), .rsp_share_o(rsp_share), .rsp_fault_o(rsp_fault),
    .rsp_fault_code_o(rsp_code), .rsp_iova_o(rsp_iova)
  );

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fetch(input logic [35:0] exp_addr, input string tag, input int stall,
                       input logic [31:0] data, input bit err);
    chk({tag, " mem_req_valid"}, 36'(mreq_valid), 36'd1);
    chk({tag, " mem_req_addr"}, mreq_addr, exp_addr);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk("R10 req held", 36'(mreq_valid), 36'd1);
      chk("R10 addr stable", mreq_addr, exp_addr);
    end
    mreq_ready = 1'b1;
    @(negedge clk);
    mreq_ready = 1'b0;
    chk({tag, " req dropped"}, 36'(mreq_valid), 36'd0);
    for (int i = 0; i < stall; i++) @(negedge clk);
    chk({tag, " rsp_ready"}, 36'(mrsp_ready), 36'd1);
    mrsp_valid = 1'b1; mrsp_data = data; mrsp_err = err;
    @(negedge clk);
    mrsp_valid = 1'b0; mrsp_err = 1'b0; mrsp_data = ~data;
  endtask

  task automatic walk(input logic [35:0] iova, input logic [35:0] base,
                      input logic [31:0] d1, input logic [31:0] d2,
                      input bit e1, input bit e2, input int stall);
    logic [35:0] e_pa, e_l1, e_l2;
    logic [1:0]  e_size;
    logic        e_share, e_fault;
    logic [3:0]  e_code;
    string       rt;
    e_l1 = base + {18'd0, iova[35:20], 2'b00};
    e_l2 = {d1[31:6], 10'd0} + {26'd0, iova[19:12], 2'b00};
    e_pa = '0; e_size = 2'd0; e_share = 1'b0; e_fault = 1'b1; e_code = 4'd1; rt = "R7";
    if (e1) begin e_code = 4'd0; rt = "R8"; end
    else if (d1[2:0] == 3'd2) begin
      e_pa = {d1[31:16], iova[19:0]}; e_share = d1[6]; e_fault = 1'b0; e_code = 4'd0; rt = "R3";
    end else if (d1[2:0] == 3'd1) begin
      if (e2) begin e_code = 4'd0; rt = "R8"; end
      else if (d2[1:0] == 2'd1) begin
        e_pa = {d2[31:12], iova[15:0]}; e_size = 2'd1; e_share = d2[4];
        e_fault = 1'b0; e_code = 4'd0; rt = "R5";
      end else if (d2[1:0] == 2'd2) begin
        e_pa = {d2[31:8], iova[11:0]}; e_size = 2'd2; e_share = d2[4];
        e_fault = 1'b0; e_code = 4'd0; rt = "R6";
      end
    end

    @(negedge clk);
    chk("R1 idle ready", 36'(req_ready), 36'd1);
    l1_base = base; req_iova = iova; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_iova = ~iova; l1_base = ~base;
    chk("R1 busy not ready", 36'(req_ready), 36'd0);
    fetch(e_l1, "R2", stall, d1, e1);
    if (!e1 && d1[2:0] == 3'd1) fetch(e_l2, "R4", stall, d2, e2);
    chk({rt, " no further fetch"}, 36'(mreq_valid), 36'd0);
    chk({rt, " rsp_valid"}, 36'(rsp_valid), 36'd1);
    chk({rt, " fault"}, 36'(rsp_fault), 36'(e_fault));
    chk({rt, " code"}, 36'(rsp_code), 36'(e_code));
    chk("R8 iova echo", rsp_iova, iova);
    if (!e_fault) begin
      chk({rt, " pa"}, rsp_pa, e_pa);
      chk({rt, " size"}, 36'(rsp_size), 36'(e_size));
      chk({rt, " share"}, 36'(rsp_share), 36'(e_share));
    end
    req_valid = 1'b1; req_iova = 36'h0_0000_1234;
    for (int i = 0; i <= stall; i++) begin
      @(negedge clk);
      chk("R9 held valid", 36'(rsp_valid), 36'd1);
      chk("R9 held fault", 36'(rsp_fault), 36'(e_fault));
      chk("R9 held iova", rsp_iova, iova);
      if (!e_fault) chk("R9 held pa", rsp_pa, e_pa);
      chk("R1 request ignored", 36'(req_ready), 36'd0);
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R9 consumed", 36'(rsp_valid), 36'd0);
    chk("R1 back idle", 36'(req_ready), 36'd1);
  endtask

  function automatic logic [35:0] iova_pat(input int i);
    if (i == 0) return 36'hF_FFFF_FFFF;
    if (i == 1) return 36'h0;
    return 36'(64'h0000_0012_3456_789B * 64'(i * 7 + 3));
  endfunction

  function automatic logic [31:0] desc_pat(input int k);
    return 32'(32'h9E37_79B9 * 32'(k + 1));
  endfunction

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=below 150000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int k = 0;
    #1;
    chk("R1 reset ready", 36'(req_ready), 36'd1);
    chk("R1 reset mem_req", 36'(mreq_valid), 36'd0);
    chk("R1 reset rsp", 36'(rsp_valid), 36'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 out of reset ready", 36'(req_ready), 36'd1);
    for (int iv = 0; iv < 8; iv++) begin
      logic [35:0] base;
      base = {iova_pat(iv + 3)[35:14], 14'd0} ^ (iv == 0 ? 36'hF_FFFF_C000 : 36'd0);
      for (int t1 = 0; t1 < 8; t1++) begin
        logic [31:0] d1;
        d1 = {desc_pat(k)[31:3], 3'(t1)};
        k++;
        if (t1 == 1) begin
          for (int t2 = 0; t2 < 4; t2++) begin
            logic [31:0] d2;
            d2 = {desc_pat(k)[31:2], 2'(t2)};
            k++;
            walk(iova_pat(iv), base, d1, d2, 1'b0, 1'b0, (iv + t2) % 3);
          end
          walk(iova_pat(iv), base, d1, desc_pat(k), 1'b0, 1'b1, iv % 3);
        end else begin
          walk(iova_pat(iv), base, d1, 32'h0, 1'b0, 1'b0, (iv + t1) % 3);
        end
      end
      walk(iova_pat(iv), base, {desc_pat(k)[31:3], 3'd2}, 32'h0, 1'b1, 1'b0, iv % 3);
      k++;
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule